// File: doc/BRIEF.md
# Sign-Extending Move and Shift Execute Unit

This unit is the move-and-shift slice of the execute stage of a 64-bit register virtual machine. Each issued operation supplies a 4-bit operation code, a class flag, a 16-bit offset field and two 64-bit operands. The operand that is shifted or overwritten is the destination; the other is the source. The unit computes four things: a plain or sign-extending register move, a left shift, a logical right shift and an arithmetic right shift. The result of a 32-bit class operation always has its upper half cleared.

The datapath is combinational and feeds a one-entry output register. That register is controlled by a two-state machine. `OS_EMPTY` means nothing was issued on the previous cycle and `out_valid` is low. `OS_FULL` means an operation was captured on the previous edge and `out_valid` is high. The machine has four transitions. EMPTY goes to FULL and FULL stays FULL when `in_valid` is high. FULL goes to EMPTY and EMPTY stays EMPTY when `in_valid` is low. Reset forces `OS_EMPTY`. When no operation is captured, `result` and `illegal` keep their last values.

Top module: `mvsh_unit`

## Requirements
- R1: Results and the `illegal` flag appear on the clock edge after the one that sampled `in_valid` high, and `out_valid` is high in exactly those cycles. Reset sets `out_valid`, `result` and `illegal` to 0.
- R2: A move (op code 4'hB) with offset 0 copies the source. In the 64-bit class (`is_wide`=1) all 64 bits are copied. In the 32-bit class (`is_wide`=0) the low 32 bits are copied and the upper 32 bits are zero.
- R3: A 32-bit class move with offset 8 or 16 sign-extends that many low source bits to 32 bits and zeroes the upper 32 bits.
- R4: A 64-bit class move with offset 8, 16 or 32 sign-extends that many low source bits to the full 64 bits.
- R5: A move with any other offset raises `illegal` and gives a result of 0. This includes offset 32 in the 32-bit class.
- R6: For shifts, the shift amount is the source operand ANDed with 6'h3F in the 64-bit class and with 5'h1F in the 32-bit class.
- R7: Left shift (op code 4'h6) shifts the destination left and drops the bits shifted out. In the 32-bit class only the low 32 bits are shifted, and the upper half of the result is zero.
- R8: Logical right shift (op code 4'h7) fills the vacated bits with zeros. In the 32-bit class it shifts only the low 32 bits and zeroes the upper half.
- R9: Arithmetic right shift (op code 4'hC) fills the vacated bits with the sign bit. The sign bit is bit 63 in the 64-bit class. In the 32-bit class it is bit 31, only the low 32 bits are shifted, and the upper half is zero.
- R10: Any other op code raises `illegal` and gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation selector |
| is_wide | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| offset | input | 16 | Instruction offset field (sign-extension width for moves) |
| dst_val | input | 64 | Destination operand |
| src_val | input | 64 | Source operand |
| out_valid | output | 1 | Result register holds a fresh operation |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered illegal-operation flag |

## Verification
The bench targets five corner cases, and each one catches a specific mistake:
- Source values whose extension bit is set while the bits just above it are clear. A design that picks the wrong sign bit, or zero-extends instead, returns a positive value where a negative one is expected.
- Shift amounts of 33, 36, 64 and 67. A design that skips the mask, or applies the 64-bit mask to a 32-bit operation, shifts everything out or leaks bits into the upper half.
- A 32-bit arithmetic shift of a destination whose bit 63 differs from bit 31. This exposes a design that reads the wrong sign bit.
- Offset 32 in the 32-bit class and unlisted offsets or op codes. A design that does not flag these returns a value with `illegal` left low.
- Reset and idle cycles. These show whether `out_valid` fails to drop.

// File: rtl/mvsh_pkg.sv
package mvsh_pkg;

    typedef enum logic [3:0] {
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_MOV  = 4'hB,
        OP_ARSH = 4'hC
    } op_e;

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } ostate_e;

endpackage

// File: rtl/mvsh_move.sv
module mvsh_move #(
    parameter int XLEN = 64,
    parameter int OFFW = 16
) (
    input  logic            is_wide,
    input  logic [OFFW-1:0] offset,
    input  logic [XLEN-1:0] src,
    output logic [XLEN-1:0] mv_res,
    output logic            mv_bad
);
    localparam int HALF = XLEN / 2;

    logic [HALF-1:0] s8_h, s16_h;
    logic [XLEN-1:0] s8_f, s16_f, s32_f;

    always_comb begin
        s8_h  = {{(HALF-8){src[7]}}, src[7:0]};
        s16_h = {{(HALF-16){src[15]}}, src[15:0]};
        s8_f  = {{(XLEN-8){src[7]}}, src[7:0]};
        s16_f = {{(XLEN-16){src[15]}}, src[15:0]};
        s32_f = {{(XLEN-32){src[31]}}, src[31:0]};
    end

    always_comb begin
        mv_res = '0;
        mv_bad = 1'b0;
        if (is_wide) begin
            case (offset)
                OFFW'(0):  mv_res = src;
                OFFW'(8):  mv_res = s8_f;
                OFFW'(16): mv_res = s16_f;
                OFFW'(32): mv_res = s32_f;
                default:   mv_bad = 1'b1;
            endcase
        end else begin
            case (offset)
                OFFW'(0):  mv_res = {{HALF{1'b0}}, src[HALF-1:0]};
                OFFW'(8):  mv_res = {{HALF{1'b0}}, s8_h};
                OFFW'(16): mv_res = {{HALF{1'b0}}, s16_h};
                default:   mv_bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/mvsh_shift.sv
module mvsh_shift #(
    parameter int XLEN = 64
) (
    input  logic                     is_wide,
    input  logic [1:0]               kind,     // 0 left, 1 logical right, 2 arithmetic right
    input  logic [XLEN-1:0]          dst,
    input  logic [$clog2(XLEN)-1:0]  shamt,
    output logic [XLEN-1:0]          sh_res
);
    localparam int HALF = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);

    logic [SHW-1:0]  amt_w;
    logic [SHW-2:0]  amt_n;
    logic [XLEN-1:0] lsh_w, rsh_w, ars_w;
    logic [HALF-1:0] lsh_n, rsh_n, ars_n;

    always_comb begin
        amt_w = shamt;
        amt_n = shamt[SHW-2:0];
        lsh_w = dst << amt_w;
        rsh_w = dst >> amt_w;
        ars_w = $unsigned($signed(dst) >>> amt_w);
        lsh_n = dst[HALF-1:0] << amt_n;
        rsh_n = dst[HALF-1:0] >> amt_n;
        ars_n = $unsigned($signed(dst[HALF-1:0]) >>> amt_n);
    end

    always_comb begin
        sh_res = '0;
        if (is_wide) begin
            case (kind)
                2'd0:    sh_res = lsh_w;
                2'd1:    sh_res = rsh_w;
                default: sh_res = ars_w;
            endcase
        end else begin
            case (kind)
                2'd0:    sh_res = {{HALF{1'b0}}, lsh_n};
                2'd1:    sh_res = {{HALF{1'b0}}, rsh_n};
                default: sh_res = {{HALF{1'b0}}, ars_n};
            endcase
        end
    end
endmodule

// File: rtl/mvsh_outreg.sv
module mvsh_outreg
    import mvsh_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] d_res,
    input  logic            d_bad,
    output logic            out_valid,
    output logic [XLEN-1:0] q_res,
    output logic            q_bad
);
    ostate_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_EMPTY: state_d = in_valid ? OS_FULL : OS_EMPTY;
            OS_FULL:  state_d = in_valid ? OS_FULL : OS_EMPTY;
            default:  state_d = OS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OS_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_res <= '0;
            q_bad <= 1'b0;
        end else if (in_valid) begin
            q_res <= d_res;
            q_bad <= d_bad;
        end
    end

    assign out_valid = (state_q == OS_FULL);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/mvsh_unit.sv
module mvsh_unit
    import mvsh_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int OFFW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op_code,
    input  logic            is_wide,
    input  logic [OFFW-1:0] offset,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            illegal
);
    localparam int HALF = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);

    logic [XLEN-1:0] mv_res, sh_res, res_c;
    logic            mv_bad, bad_c;
    logic [1:0]      sh_kind;

    mvsh_move #(.XLEN(XLEN), .OFFW(OFFW)) u_move (
        .is_wide (is_wide),
        .offset  (offset),
        .src     (src_val),
        .mv_res  (mv_res),
        .mv_bad  (mv_bad)
    );

    mvsh_shift #(.XLEN(XLEN)) u_shift (
        .is_wide (is_wide),
        .kind    (sh_kind),
        .dst     (dst_val),
        .shamt   (src_val[SHW-1:0]),
        .sh_res  (sh_res)
    );

    always_comb begin
        sh_kind = 2'd2;
        res_c   = '0;
        bad_c   = 1'b0;
        case (op_code)
            OP_LSH:  begin sh_kind = 2'd0; res_c = sh_res; end
            OP_RSH:  begin sh_kind = 2'd1; res_c = sh_res; end
            OP_ARSH: begin sh_kind = 2'd2; res_c = sh_res; end
            OP_MOV:  begin res_c = mv_bad ? '0 : mv_res; bad_c = mv_bad; end
            default: bad_c = 1'b1;
        endcase
    end

    mvsh_outreg #(.XLEN(XLEN)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d_res     (res_c),
        .d_bad     (bad_c),
        .out_valid (out_valid),
        .q_res     (result),
        .q_bad     (illegal)
    );

    // R2
    wide_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_MOV && is_wide && offset == '0)
        |=> (result == $past(src_val) && !illegal));
    // R5
    narrow_off32_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_MOV && !is_wide && offset == OFFW'(32))
        |=> (illegal && result == '0));
    // R7
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_wide && !bad_c) |=> (result[XLEN-1:HALF] == '0));
    // R9
    wide_arsh_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_ARSH && is_wide && dst_val[XLEN-1])
        |=> result[XLEN-1]);
    // R10
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code != OP_LSH && op_code != OP_RSH &&
         op_code != OP_MOV && op_code != OP_ARSH) |=> illegal);
endmodule

// File: tb/mvsh_unit_tb.sv
module mvsh_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = 4'h0;
    logic        is_wide = 1'b0;
    logic [15:0] offset = 16'h0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mvsh_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .is_wide(is_wide), .offset(offset), .dst_val(dst_val), .src_val(src_val),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [3:0]  op;
        logic        wide;
        logic [15:0] off;
        logic [63:0] dst;
        logic [63:0] src;
        logic [63:0] exp;
        logic        ill;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R2 copies
        '{8'd2, 4'hB, 1'b1, 16'd0,  64'h0, 64'h8123_4567_89AB_CDEF, 64'h8123_4567_89AB_CDEF, 1'b0},
        '{8'd2, 4'hB, 1'b0, 16'd0,  64'h0, 64'h8123_4567_89AB_CDEF, 64'h0000_0000_89AB_CDEF, 1'b0},
        // R3 narrow sign extension
        '{8'd3, 4'hB, 1'b0, 16'd8,  64'h0, 64'h0000_0000_0000_0080, 64'h0000_0000_FFFF_FF80, 1'b0},
        '{8'd3, 4'hB, 1'b0, 16'd16, 64'h0, 64'hFFFF_FFFF_1234_7FFF, 64'h0000_0000_0000_7FFF, 1'b0},
        // R4 wide sign extension
        '{8'd4, 4'hB, 1'b1, 16'd8,  64'h0, 64'h0000_0000_0000_00FE, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0},
        '{8'd4, 4'hB, 1'b1, 16'd16, 64'h0, 64'h0000_0000_0000_8001, 64'hFFFF_FFFF_FFFF_8001, 1'b0},
        '{8'd4, 4'hB, 1'b1, 16'd32, 64'h0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_8000_0000, 1'b0},
        '{8'd4, 4'hB, 1'b1, 16'd32, 64'h0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 1'b0},
        // R5 bad offsets
        '{8'd5, 4'hB, 1'b0, 16'd32, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b1},
        '{8'd5, 4'hB, 1'b1, 16'd24, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b1},
        // R7 / R6 left shifts with masking
        '{8'd7, 4'h6, 1'b1, 16'd0,  64'h1, 64'h43, 64'h8, 1'b0},
        '{8'd7, 4'h6, 1'b0, 16'd0,  64'hFFFF_FFFF_8000_0001, 64'd33, 64'h2, 1'b0},
        // R6 amount 64 masks to 0
        '{8'd6, 4'h6, 1'b1, 16'd0,  64'h1234, 64'd64, 64'h1234, 1'b0},
        // R8 logical right
        '{8'd8, 4'h7, 1'b1, 16'd0,  64'h8000_0000_0000_0000, 64'd63, 64'h1, 1'b0},
        '{8'd8, 4'h7, 1'b0, 16'd0,  64'hFFFF_FFFF_8000_0000, 64'd31, 64'h1, 1'b0},
        // R9 arithmetic right
        '{8'd9, 4'hC, 1'b1, 16'd0,  64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000, 1'b0},
        '{8'd9, 4'hC, 1'b0, 16'd0,  64'h0000_0000_8000_0000, 64'd36, 64'h0000_0000_F800_0000, 1'b0},
        '{8'd9, 4'hC, 1'b0, 16'd0,  64'hFFFF_FFFF_4000_0000, 64'd1, 64'h0000_0000_2000_0000, 1'b0},
        // R10 unknown op code
        '{8'd10, 4'h1, 1'b1, 16'd0, 64'h5, 64'h3, 64'h0, 1'b1}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic w, input logic [15:0] off,
                         input logic [63:0] d, input logic [63:0] s);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; is_wide = w; offset = off; dst_val = d; src_val = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 reset out_valid", {63'b0, out_valid}, 64'h0);
        chk("R1 reset result", result, 64'h0);
        chk("R1 reset illegal", {63'b0, illegal}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].wide, VECS[i].off, VECS[i].dst, VECS[i].src);
            chk($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].exp);
            chk($sformatf("R%0d vec %0d illegal", VECS[i].req, i), {63'b0, illegal}, {63'b0, VECS[i].ill});
            chk($sformatf("R1 vec %0d out_valid", i), {63'b0, out_valid}, 64'h1);
        end

        // R1 idle cycle drops out_valid, result held
        @(negedge clk);
        in_valid = 1'b0; op_code = 4'h6; dst_val = 64'hFFFF; src_val = 64'd1;
        @(posedge clk);
        #1;
        chk("R1 idle out_valid", {63'b0, out_valid}, 64'h0);
        chk("R1 idle result held", result, 64'h0);

        // R9 narrow arithmetic shift ignores bit 63 as sign
        issue(4'hC, 1'b0, 16'd0, 64'h8000_0000_7FFF_FFFF, 64'd31);
        chk("R9 narrow sign from bit 31", result, 64'h0);
        // R5 narrow offset 1 illegal
        issue(4'hB, 1'b0, 16'd1, 64'h0, 64'hFF);
        chk("R5 offset 1 illegal", {63'b0, illegal}, 64'h1);

        // R1 reset mid-run clears outputs
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1 async reset out_valid", {63'b0, out_valid}, 64'h0);
        chk("R1 async reset illegal", {63'b0, illegal}, 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule